// File: doc/BRIEF.md
# Dual-Mode Compare/Capture Timer

A single up-counting timer channel with a small register port. A load register holds a reload value. Its upper half has a second meaning that depends on the counter width mode. In narrow mode the counter is 16 bits wide, and the upper half of the load register is a compare value. Each match against the compare value drives an external output as a toggle or as a one-cycle pulse. In wide mode the counter is 32 bits wide, and the whole load register is the reload value.

The count register also changes meaning with the mode. In narrow mode it returns a captured count in its upper half and the live count in its lower half. In wide mode it returns the full live count. A capture input is synchronized with two flops, and each of its rising edges latches the counter. Match and capture events set sticky status flags, which software clears by writing one. The interrupt line reflects each flag gated by its own enable.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, all four registers read zero and `tmr_out` and `irq` are low.
- R2: A write to the control register that sets `enable` (bit 0) while it is clear loads the counter on that clock edge. In narrow mode the load takes load[15:0], zero-extended. In wide mode (control bit 1) it takes the full 32 bits.
- R3: While enabled, the counter increases by one per clock. While disabled, it holds its value.
- R4: Terminal count is 0xFFFF in narrow mode and 0xFFFFFFFF in wide mode. At terminal count the counter reloads if `reload_en` (control bit 2) is set, and otherwise it stops there.
- R5: In narrow mode with toggle output (control bit 3 clear), `tmr_out` inverts on the clock edge that ends a running cycle in which count[15:0] equals load[31:16]. `tmr_out` resets low.
- R6: With pulse output (control bit 3 set), `tmr_out` is high for exactly the one cycle that follows each match. Otherwise it is low.
- R7: A match sets the sticky match flag, read as status bit 0, on the same edge that updates `tmr_out`.
- R8: The capture input passes through a two-flop synchronizer. In narrow mode, on the third clock edge after the input rises, the counter is latched into count-register bits 31:16, and the capture flag (status bit 1) is set.
- R9: In wide mode, capture edges neither set the capture flag nor change the captured value.
- R10: Writing one to a status bit clears that flag, and writing zero leaves it. `irq` is high when the match flag is set and match_ie (control bit 4) is set, or when the capture flag is set and cap_ie (control bit 5) is set.
- R11: Register offsets are: 0 control, 1 load, 2 count, 3 status. Control and load read back as written. Writes to offset 2 have no effect.
- R12: Offset 2 reads {capture[15:0], count[15:0]} in narrow mode and the full count in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Compare output, toggle or pulse |
| irq | output | 1 | Interrupt request |

## Verification
A write takes effect on the clock edge that samples it. A count read taken just after the enabling write therefore shows the reload value, and after N more edges it shows the reload value plus N, subject to terminal-count handling. `tmr_out` and the match flag change on the edge that ends the matching cycle, so the bench expects the toggle two edges after enable when the reload value lies one below the compare value. Capture results appear three edges after the input rises, and the bench checks that they are still absent after two. All outputs are sampled at the falling edge following these counts, and reads settle for a short delay after `rd_addr` changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned REG_ADDR_W = 2;
    localparam int unsigned CTRL_W     = 6;

    // Control register layout, bit 0 at the bottom.
    typedef struct packed {
        logic cap_ie;      // bit 5
        logic match_ie;    // bit 4
        logic pulse_mode;  // bit 3
        logic reload_en;   // bit 2
        logic wide;        // bit 1
        logic enable;      // bit 0
    } ctrl_t;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LOAD  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic capture;
        logic match;
    } tmr_flags_t;

    function automatic reg_sel_e decode_sel(input logic [REG_ADDR_W-1:0] a);
        return reg_sel_e'(a);
    endfunction

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    output ctrl_t                 ctrl,
    output logic [CNT_W-1:0]      load_val,
    output logic                  en_load,
    output tmr_flags_t            stat_clr
);

    reg_sel_e sel;
    logic     wr_ctrl;
    logic     wr_load;
    logic     wr_stat;
    ctrl_t    ctrl_new;

    always_comb begin
        sel      = decode_sel(wr_addr);
        wr_ctrl  = wr_en && (sel == SEL_CTRL);
        wr_load  = wr_en && (sel == SEL_LOAD);
        wr_stat  = wr_en && (sel == SEL_STAT);
        ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
        en_load  = wr_ctrl && ctrl_new.enable && !ctrl.enable;
        stat_clr = wr_stat ? tmr_flags_t'(wr_data[1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            load_val <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_new;
            if (wr_load) load_val <= wr_data;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en_load,
    output logic [CNT_W-1:0] cnt,
    output logic             match_evt,
    output logic             tmr_out
);

    localparam int unsigned HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  reload_val;
    logic [CNT_W-1:0]  cnt_inc;
    logic [HALF_W-1:0] cmp_val;
    logic              tc_hit;
    logic              running;

    always_comb begin
        cmp_val = load_val[CNT_W-1:HALF_W];
        if (ctrl.wide) begin
            reload_val = load_val;
            cnt_inc    = cnt + 1'b1;
            tc_hit     = &cnt;
        end else begin
            reload_val = {{HALF_W{1'b0}}, load_val[HALF_W-1:0]};
            cnt_inc    = {{HALF_W{1'b0}}, cnt[HALF_W-1:0] + 1'b1};
            tc_hit     = &cnt[HALF_W-1:0];
        end
        running   = ctrl.enable && !(tc_hit && !ctrl.reload_en);
        match_evt = running && !ctrl.wide && (cnt[HALF_W-1:0] == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en_load) begin
            cnt <= reload_val;
        end else if (ctrl.enable) begin
            if (tc_hit) begin
                if (ctrl.reload_en) cnt <= reload_val;
            end else begin
                cnt <= cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_out <= 1'b0;
        end else if (ctrl.pulse_mode) begin
            tmr_out <= match_evt;
        end else if (match_evt) begin
            tmr_out <= ~tmr_out;
        end
    end

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_in,
    input  logic                  wide,
    input  logic [CNT_W-1:0]      cnt,
    output logic [CNT_W/2-1:0]    cap_val,
    output logic                  cap_evt
);

    localparam int unsigned HALF_W = CNT_W / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= cap_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign cap_evt = sync_q[SYNC_STAGES-1] && !prev_q && !wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            cap_val <= '0;
        end else begin
            prev_q <= sync_q[SYNC_STAGES-1];
            if (cap_evt) cap_val <= cnt[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [1:0]            rd_addr,
    output logic [CNT_W-1:0]      rd_data,
    input  logic                  cap_in,
    output logic                  tmr_out,
    output logic                  irq
);

    localparam int unsigned HALF_W = CNT_W / 2;

    ctrl_t             ctrl;
    logic [CNT_W-1:0]  load_val;
    logic              en_load;
    tmr_flags_t        stat_clr;
    logic [CNT_W-1:0]  cnt;
    logic              match_evt;
    logic [HALF_W-1:0] cap_val;
    logic              cap_evt;
    logic              m_flag;
    logic              c_flag;

    tmr_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .load_val (load_val),
        .en_load  (en_load),
        .stat_clr (stat_clr)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .load_val  (load_val),
        .en_load   (en_load),
        .cnt       (cnt),
        .match_evt (match_evt),
        .tmr_out   (tmr_out)
    );

    tmr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_in  (cap_in),
        .wide    (ctrl.wide),
        .cnt     (cnt),
        .cap_val (cap_val),
        .cap_evt (cap_evt)
    );

    // Sticky flags: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            m_flag <= 1'b0;
            c_flag <= 1'b0;
        end else begin
            m_flag <= match_evt || (m_flag && !stat_clr.match);
            c_flag <= cap_evt   || (c_flag && !stat_clr.capture);
        end
    end

    assign irq = (m_flag && ctrl.match_ie) || (c_flag && ctrl.cap_ie);

    always_comb begin
        rd_data = '0;
        unique case (decode_sel(rd_addr))
            SEL_CTRL:  rd_data[CTRL_W-1:0] = ctrl;
            SEL_LOAD:  rd_data = load_val;
            SEL_COUNT: rd_data = ctrl.wide ? cnt : {cap_val, cnt[HALF_W-1:0]};
            SEL_STAT:  rd_data[1:0] = {c_flag, m_flag};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input ctrl_t            ctrl,
    input logic             en_load,
    input logic [CNT_W-1:0] cnt,
    input logic             match_evt,
    input logic             cap_evt,
    input logic             tmr_out,
    input logic             m_flag,
    input logic             c_flag,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data
);

    localparam int unsigned HALF_W = CNT_W / 2;

    logic at_tc;
    logic clr_m;
    logic clr_c;
    assign at_tc = ctrl.wide ? (&cnt) : (&cnt[HALF_W-1:0]);
    assign clr_m = wr_en && (wr_addr == 2'd3) && wr_data[0];
    assign clr_c = wr_en && (wr_addr == 2'd3) && wr_data[1];

    // R3: a disabled counter keeps its value
    a_r3_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !en_load) |=> $stable(cnt));

    // R4: without reload the counter parks at terminal count
    a_r4_park_at_tc: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !ctrl.reload_en && at_tc) |=> $stable(cnt));

    // R5: wide toggle mode never moves the output
    a_r5_wide_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctrl.wide && !ctrl.pulse_mode) |=> $stable(tmr_out));

    // R7: match flag stays set until cleared
    a_r7_match_sticky: assert property (@(posedge clk) disable iff (rst)
        (m_flag && !clr_m) |=> m_flag);

    // R7: a match sets the flag
    a_r7_match_sets: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> m_flag);

    // R8: a narrow-mode capture sets its flag
    a_r8_cap_sets: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> c_flag);

    // R10: clear without a new event drops the capture flag
    a_r10_w1c_capture: assert property (@(posedge clk) disable iff (rst)
        (clr_c && !cap_evt) |=> !c_flag);

endmodule

bind dual_mode_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .en_load   (en_load),
    .cnt       (cnt),
    .match_evt (match_evt),
    .cap_evt   (cap_evt),
    .tmr_out   (tmr_out),
    .m_flag    (m_flag),
    .c_flag    (c_flag),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/dual_mode_timer_test.sv
module dual_mode_timer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        cap_in = 1'b0;
    logic        tmr_out;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_mode_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq)
    );

    // wide, reload_en, load value, edges after enable, expected count read
    typedef struct packed {
        logic        wide;
        logic        re;
        logic [31:0] ld;
        logic [7:0]  n;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b1, 32'h0000_0010, 8'd5, 32'h0000_0015},
        '{1'b0, 1'b1, 32'h0000_FFFD, 8'd4, 32'h0000_FFFE},
        '{1'b0, 1'b0, 32'h0000_FFFD, 8'd5, 32'h0000_FFFF},
        '{1'b0, 1'b1, 32'h1234_ABCD, 8'd2, 32'h0000_ABCF},
        '{1'b1, 1'b1, 32'h0001_FFFE, 8'd3, 32'h0002_0001},
        '{1'b1, 1'b1, 32'hFFFF_FFFE, 8'd2, 32'hFFFF_FFFE},
        '{1'b1, 1'b0, 32'hFFFF_FFFE, 8'd4, 32'hFFFF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        o0;
        step(3);
        rst = 1'b0;
        step(1);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 tmr_out", {31'b0, tmr_out}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 R3 R4 R12: table of load/run/read vectors
        foreach (VECS[k]) begin
            wr(2'd0, {29'b0, VECS[k].re, VECS[k].wide, 1'b0});
            wr(2'd1, VECS[k].ld);
            wr(2'd0, {29'b0, VECS[k].re, VECS[k].wide, 1'b1});
            step(int'(VECS[k].n));
            rd(2'd2, v);
            check($sformatf("R4/R12 vector %0d", k), v, VECS[k].exp);
        end
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h3);

        // R5 R7: toggle mode, compare FFFF, reload FFFE, reload on
        wr(2'd1, 32'hFFFF_FFFE);
        wr(2'd0, 32'h15);
        o0 = tmr_out;
        step(1);
        check("R5 no toggle yet", {31'b0, tmr_out}, {31'b0, o0});
        step(1);
        check("R5 first toggle", {31'b0, tmr_out}, {31'b0, ~o0});
        check("R7 irq on match", {31'b0, irq}, 32'h1);
        rd(2'd3, v);
        check("R7 match flag", v, 32'h1);
        step(1);
        check("R5 held", {31'b0, tmr_out}, {31'b0, ~o0});
        step(1);
        check("R5 second toggle", {31'b0, tmr_out}, {31'b0, o0});
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h1);
        rd(2'd3, v);
        check("R10 w1c match", v, 32'h0);
        check("R10 irq cleared", {31'b0, irq}, 32'h0);

        // R6 R10: pulse mode, match interrupt disabled
        wr(2'd0, 32'h0C);
        wr(2'd0, 32'h0D);
        check("R6 low after enable", {31'b0, tmr_out}, 32'h0);
        step(1);
        check("R6 low before match", {31'b0, tmr_out}, 32'h0);
        step(1);
        check("R6 pulse high", {31'b0, tmr_out}, 32'h1);
        step(1);
        check("R6 pulse one cycle", {31'b0, tmr_out}, 32'h0);
        rd(2'd3, v);
        check("R10 flag without enable", v, 32'h1);
        check("R10 irq gated", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h3);

        // R8: capture in narrow mode with counter frozen at 0x43
        wr(2'd1, 32'h0000_0042);
        wr(2'd0, 32'h01);
        wr(2'd0, 32'h20);
        cap_in = 1'b1;
        step(2);
        rd(2'd3, v);
        check("R8 not yet captured", v, 32'h0);
        step(1);
        rd(2'd2, v);
        check("R8 captured value", v, 32'h0043_0043);
        rd(2'd3, v);
        check("R8 capture flag", v, 32'h2);
        check("R8 irq on capture", {31'b0, irq}, 32'h1);
        cap_in = 1'b0;
        step(2);
        wr(2'd3, 32'h2);
        check("R10 w1c capture", {31'b0, irq}, 32'h0);

        // R9: capture ignored in wide mode
        wr(2'd0, 32'h22);
        rd(2'd2, v);
        check("R12 wide read", v, 32'h0000_0043);
        cap_in = 1'b1;
        step(4);
        cap_in = 1'b0;
        step(3);
        rd(2'd3, v);
        check("R9 no capture flag", v, 32'h0);
        check("R9 no irq", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h20);
        rd(2'd2, v);
        check("R9 capture unchanged", v, 32'h0043_0043);

        // R11: register map and read-only count
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, v);
        check("R11 count write ignored", v, 32'h0043_0043);
        rd(2'd0, v);
        check("R11 ctrl readback", v, 32'h20);
        rd(2'd1, v);
        check("R11 load readback", v, 32'h42);

        // R2: enable loads low half in narrow mode, full value in wide mode
        wr(2'd1, 32'h1234_5678);
        wr(2'd0, 32'h01);
        rd(2'd2, v);
        check("R2 narrow load", v, 32'h0043_5678);
        wr(2'd0, 32'h02);
        wr(2'd0, 32'h03);
        rd(2'd2, v);
        check("R2 wide load", v, 32'h1234_5678);
        wr(2'd0, 32'h02);
        step(3);
        rd(2'd2, v);
        check("R3 hold when disabled", v, 32'h1234_5679);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule